// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node of a small shared-memory system with `NPROC` processors. For every memory block it tracks a sharing state and a presence vector with one bit per processor. The sharing state is one of three values. Uncached means no cache holds the block. Shared means one or more caches hold read-only copies. Exclusive means exactly one cache holds a modified copy and memory is stale. The block also stores the data of every memory block.

Caches send read misses, write misses and write-backs on the request stream. The controller then drives coherence commands on the command stream: an invalidate to a sharer, a fetch-to-shared to an owner, or a take-away to an owner. Caches answer each command with one pulse on the acknowledge input. An owner's acknowledge carries its dirty data. When the transaction is complete, the controller returns one reply carrying the block data.

The request, command and reply streams use valid/ready. A source keeps valid high and its payload unchanged until the cycle in which ready is also high. The transfer happens on that clock edge. The acknowledge input has no ready signal and is always accepted. The controller runs one transaction at a time. While a transaction is in progress, new requests wait with `req_ready` low.

Top module: `coh_dir`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and holds data 0. `req_ready` is 1, and `cmd_valid` and `rsp_valid` are 0.
- R2: A read miss (`req_op`=0) on an Uncached or Shared block, or a write miss (`req_op`=1) on an Uncached block, issues no command. The reply carries the memory data.
- R3: A write miss on a Shared block sends exactly one invalidate (`cmd_kind`=0) to each sharer other than the requester, and never to the requester.
- R4: The reply to a transaction that issued commands is sent only after one acknowledge has arrived for every command sent.
- R5: A read miss on an Exclusive block sends one fetch-to-shared (`cmd_kind`=1) to the owner. The reply carries the owner's data, memory takes that data, and the block becomes Shared with both the owner and the reader marked.
- R6: A write miss on an Exclusive block owned by another processor sends one take-away (`cmd_kind`=2) to the owner. The reply forwards the owner's data, and the block stays Exclusive with only the new writer marked.
- R7: A write-back (`req_op`=2) stores `req_data` in memory without issuing a command. It replies with that data and returns the block to Uncached with an empty vector, so a later read miss issues no command and returns the written value.
- R8: `req_ready` is low from the edge that accepts a request until the edge that hands over its reply.
- R9: While `cmd_valid` or `rsp_valid` is high and its ready is low, valid stays high and the payload stays unchanged on the next cycle.
- R10: Across any mix of requests, at most one cache holds a modified copy of a block, and no other cache holds a copy of that block. Every read miss returns the most recently written value of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can take a request |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_blk | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Write-back data |
| cmd_valid | output | 1 | Coherence command valid |
| cmd_ready | input | 1 | Target cache takes the command |
| cmd_dst | output | $clog2(NPROC) | Target processor |
| cmd_kind | output | 2 | 0 invalidate, 1 fetch-to-shared, 2 take-away |
| cmd_blk | output | $clog2(NBLK) | Block index |
| ack_valid | input | 1 | One acknowledge for an earlier command |
| ack_dirty | input | 1 | Acknowledge carries owner data |
| ack_data | input | DW | Owner data |
| rsp_valid | output | 1 | Reply valid |
| rsp_ready | input | 1 | Requester takes the reply |
| rsp_dst | output | $clog2(NPROC) | Requester |
| rsp_blk | output | $clog2(NBLK) | Block index |
| rsp_data | output | DW | Block data |

## Verification
The bench builds the controller with 3 processors, 2 blocks and 8-bit data. With only two blocks, random traffic from three caches keeps hitting the same entry, so every state change is reached many times. With three processors, a write can find two other sharers, and the bench checks that each one is invalidated and acknowledged. The command and reply ready signals are withheld at random. This holds commands and replies stalled while acknowledges are still arriving.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {DIR_U = 2'd0, DIR_S = 2'd1, DIR_E = 2'd2} dir_st_e;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_WB = 2'd2} req_op_e;
  typedef enum logic [1:0] {CMD_INV = 2'd0, CMD_FETCH = 2'd1, CMD_TAKE = 2'd2} cmd_e;
  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_SEND, F_WAIT, F_REPLY} fsm_e;
endpackage

// File: rtl/coh_pick_low.sv
module coh_pick_low #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table #(
  parameter int NBLK  = 4,
  parameter int NPROC = 3,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    idx,
  output logic [1:0]       rd_st,
  output logic [NPROC-1:0] rd_vec,
  input  logic             wr_en,
  input  logic [1:0]       wr_st,
  input  logic [NPROC-1:0] wr_vec
);
  logic [1:0]       st_w  [NBLK];
  logic [NPROC-1:0] vec_w [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    logic [1:0]       st_q;
    logic [NPROC-1:0] vec_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= coh_pkg::DIR_U;
        vec_q <= '0;
      end else if (wr_en && idx == BW'(g)) begin
        st_q  <= wr_st;
        vec_q <= wr_vec;
      end
    end
    assign st_w[g]  = st_q;
    assign vec_w[g] = vec_q;
  end

  assign rd_st  = st_w[idx];
  assign rd_vec = vec_w[idx];
endmodule

// File: rtl/coh_blk_mem.sv
module coh_blk_mem #(
  parameter int NBLK = 4,
  parameter int DW   = 8,
  parameter int BW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] word_w [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q <= '0;
      else if (wr_en && idx == BW'(g))     word_q <= wr_data;
    end
    assign word_w[g] = word_q;
  end

  assign rd_data = word_w[idx];
endmodule

// File: rtl/coh_dir.sv
module coh_dir #(
  parameter int NPROC = 3,
  parameter int NBLK  = 4,
  parameter int DW    = 8,
  localparam int SW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_src,
  input  logic [1:0]    req_op,
  input  logic [BW-1:0] req_blk,
  input  logic [DW-1:0] req_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [SW-1:0] cmd_dst,
  output logic [1:0]    cmd_kind,
  output logic [BW-1:0] cmd_blk,
  input  logic          ack_valid,
  input  logic          ack_dirty,
  input  logic [DW-1:0] ack_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [SW-1:0] rsp_dst,
  output logic [BW-1:0] rsp_blk,
  output logic [DW-1:0] rsp_data
);
  import coh_pkg::*;

  localparam int PCW = $clog2(NPROC + 1);

  fsm_e             state, state_n;
  logic [SW-1:0]    q_src;
  logic [1:0]       q_op;
  logic [BW-1:0]    q_blk;
  logic [DW-1:0]    q_data;
  logic [NPROC-1:0] mask, mask_n;
  logic [1:0]       kind, kind_n;
  logic [PCW-1:0]   pend;
  logic [DW-1:0]    fwd;
  logic [DW-1:0]    rsp_q, rsp_n;

  logic [1:0]       rd_st;
  logic [NPROC-1:0] rd_vec;
  logic             dwe;
  logic [1:0]       dst;
  logic [NPROC-1:0] dvec;
  logic [DW-1:0]    mem_rd;
  logic             mwe;
  logic [DW-1:0]    mdat;
  logic [SW-1:0]    pick;
  logic [NPROC-1:0] src_bit, pick_bit;
  logic             cmd_hs;

  coh_dir_table #(.NBLK(NBLK), .NPROC(NPROC), .BW(BW)) u_table (
    .clk(clk), .rst_n(rst_n), .idx(q_blk), .rd_st(rd_st), .rd_vec(rd_vec),
    .wr_en(dwe), .wr_st(dst), .wr_vec(dvec)
  );

  coh_blk_mem #(.NBLK(NBLK), .DW(DW), .BW(BW)) u_mem (
    .clk(clk), .rst_n(rst_n), .idx(q_blk), .rd_data(mem_rd),
    .wr_en(mwe), .wr_data(mdat)
  );

  coh_pick_low #(.N(NPROC), .IW(SW)) u_pick (.mask(mask), .idx(pick));

  assign src_bit  = {{(NPROC-1){1'b0}}, 1'b1} << q_src;
  assign pick_bit = {{(NPROC-1){1'b0}}, 1'b1} << pick;
  assign cmd_hs   = cmd_valid && cmd_ready;

  always_comb begin
    state_n = state;
    mask_n  = mask;
    kind_n  = kind;
    rsp_n   = rsp_q;
    dwe     = 1'b0;
    dst     = DIR_U;
    dvec    = '0;
    mwe     = 1'b0;
    mdat    = fwd;
    case (state)
      F_IDLE: if (req_valid) state_n = F_LOOK;
      F_LOOK: begin
        if (q_op == OP_RD) begin
          if (rd_st == DIR_E) begin
            mask_n = rd_vec; kind_n = CMD_FETCH; state_n = F_SEND;
          end else begin
            dwe = 1'b1; dst = DIR_S; dvec = rd_vec | src_bit;
            rsp_n = mem_rd; state_n = F_REPLY;
          end
        end else if (q_op == OP_WR) begin
          if (rd_st == DIR_E) begin
            mask_n = rd_vec; kind_n = CMD_TAKE; state_n = F_SEND;
          end else if ((rd_vec & ~src_bit) != '0) begin
            mask_n = rd_vec & ~src_bit; kind_n = CMD_INV; state_n = F_SEND;
          end else begin
            dwe = 1'b1; dst = DIR_E; dvec = src_bit;
            rsp_n = mem_rd; state_n = F_REPLY;
          end
        end else begin
          mwe = 1'b1; mdat = q_data;
          dwe = 1'b1; dst = DIR_U; dvec = '0;
          rsp_n = q_data; state_n = F_REPLY;
        end
      end
      F_SEND: if (cmd_ready) begin
        mask_n = mask & ~pick_bit;
        if (mask_n == '0) state_n = F_WAIT;
      end
      F_WAIT: if (pend == '0) begin
        state_n = F_REPLY;
        if (kind == CMD_INV) begin
          dwe = 1'b1; dst = DIR_E; dvec = src_bit; rsp_n = mem_rd;
        end else if (kind == CMD_FETCH) begin
          mwe = 1'b1; dwe = 1'b1; dst = DIR_S; dvec = rd_vec | src_bit; rsp_n = fwd;
        end else begin
          mwe = 1'b1; dwe = 1'b1; dst = DIR_E; dvec = src_bit; rsp_n = fwd;
        end
      end
      F_REPLY: if (rsp_ready) state_n = F_IDLE;
      default: state_n = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= F_IDLE;
      q_src  <= '0;
      q_op   <= '0;
      q_blk  <= '0;
      q_data <= '0;
      mask   <= '0;
      kind   <= '0;
      pend   <= '0;
      fwd    <= '0;
      rsp_q  <= '0;
    end else begin
      state <= state_n;
      mask  <= mask_n;
      kind  <= kind_n;
      rsp_q <= rsp_n;
      pend  <= pend + PCW'(cmd_hs) - PCW'(ack_valid);
      if (ack_valid && ack_dirty) fwd <= ack_data;
      if (state == F_IDLE && req_valid) begin
        q_src  <= req_src;
        q_op   <= req_op;
        q_blk  <= req_blk;
        q_data <= req_data;
      end
    end
  end

  assign req_ready = (state == F_IDLE);
  assign cmd_valid = (state == F_SEND);
  assign cmd_dst   = pick;
  assign cmd_kind  = kind;
  assign cmd_blk   = q_blk;
  assign rsp_valid = (state == F_REPLY);
  assign rsp_dst   = q_src;
  assign rsp_blk   = q_blk;
  assign rsp_data  = rsp_q;
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
  parameter int NPROC = 3,
  parameter int NBLK  = 4,
  parameter int DW    = 8,
  localparam int SW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] req_src,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [SW-1:0] cmd_dst,
  input logic [1:0]    cmd_kind,
  input logic [BW-1:0] cmd_blk,
  input logic          ack_valid,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [SW-1:0] rsp_dst,
  input logic [BW-1:0] rsp_blk,
  input logic [DW-1:0] rsp_data
);
  localparam int PCW = $clog2(NPROC + 1) + 1;

  logic [SW-1:0]  src_q;
  logic [PCW-1:0] open_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      open_cnt <= '0;
    end else begin
      if (req_valid && req_ready) src_q <= req_src;
      open_cnt <= open_cnt + PCW'(cmd_valid && cmd_ready) - PCW'(ack_valid);
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_dst) && $stable(rsp_blk));
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_dst) && $stable(cmd_kind) && $stable(cmd_blk));
  // R8
  busy_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready);
  // R8
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> !req_ready);
  // R3
  inv_not_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd0 |-> cmd_dst != src_q);
  // R4
  acks_done_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> open_cnt == '0);
  // R6
  single_owner_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_kind != 2'd0 |=> !cmd_valid);
endmodule

bind coh_dir coh_dir_chk #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dst(cmd_dst), .cmd_kind(cmd_kind),
  .cmd_blk(cmd_blk), .ack_valid(ack_valid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_dst(rsp_dst), .rsp_blk(rsp_blk), .rsp_data(rsp_data)
);

// File: tb/tb_coh_dir.sv
module tb_coh_dir;
  localparam int NP = 3;
  localparam int NB = 2;
  localparam int DW = 8;
  localparam int SW = 2;
  localparam int BW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [SW-1:0] req_src = '0;
  logic [1:0]    req_op = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [SW-1:0] cmd_dst;
  logic [1:0]    cmd_kind;
  logic [BW-1:0] cmd_blk;
  logic          ack_valid = 1'b0;
  logic          ack_dirty = 1'b0;
  logic [DW-1:0] ack_data = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [SW-1:0] rsp_dst;
  logic [BW-1:0] rsp_blk;
  logic [DW-1:0] rsp_data;

  always #10 clk = ~clk;

  coh_dir #(.NPROC(NP), .NBLK(NB), .DW(DW)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit cv [NP][NB];
  bit cd [NP][NB];
  logic [DW-1:0] cdat [NP][NB];
  logic [DW-1:0] golden [NB];
  int cur_src = 0;
  string cur_tag = "R1";
  int outst = 0;
  int ncmd = 0;

  typedef struct packed {logic [SW-1:0] dst; logic [BW-1:0] blk; logic [DW-1:0] data;} exp_t;
  exp_t exp_q[$];
  logic [DW:0] ack_q[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // cache side: acknowledges, commands, replies (scoreboard monitor)
  always @(negedge clk) begin : cache_side
    int d;
    int b;
    exp_t e;
    if (rst_n) begin
      if (ack_q.size() > 0) begin
        {ack_dirty, ack_data} = ack_q.pop_front();
        ack_valid = 1'b1;
        outst--;
      end else begin
        ack_valid = 1'b0;
        ack_dirty = 1'b0;
      end
      cmd_ready = ($urandom_range(3) != 0);
      if (cmd_valid && cmd_ready) begin
        d = int'(cmd_dst);
        b = int'(cmd_blk);
        ncmd++;
        outst++;
        if (cmd_kind == 2'd0) begin
          chk(cv[d][b] && !cd[d][b] && d != cur_src, "R3", "invalidate target holds clean copy", d, cur_src);
          cv[d][b] = 1'b0;
          ack_q.push_back({1'b0, {DW{1'b0}}});
        end else if (cmd_kind == 2'd1) begin
          chk(cd[d][b], "R5", "fetch target owns block", int'(cd[d][b]), 1);
          cd[d][b] = 1'b0;
          ack_q.push_back({1'b1, cdat[d][b]});
        end else if (cmd_kind == 2'd2) begin
          chk(cd[d][b], "R6", "take-away target owns block", int'(cd[d][b]), 1);
          cv[d][b] = 1'b0;
          cd[d][b] = 1'b0;
          ack_q.push_back({1'b1, cdat[d][b]});
        end else begin
          chk(1'b0, "R3", "command kind", int'(cmd_kind), 0);
        end
      end
      rsp_ready = ($urandom_range(3) != 0);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected reply", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(rsp_dst == e.dst, cur_tag, "reply destination", int'(rsp_dst), int'(e.dst));
          chk(rsp_blk == e.blk, cur_tag, "reply block", int'(rsp_blk), int'(e.blk));
          chk(rsp_data == e.data, cur_tag, "reply data", int'(rsp_data), int'(e.data));
          chk(outst == 0, "R4", "acknowledges outstanding at reply", outst, 0);
        end
      end
    end
  end

  task automatic check_invariant();
    for (int b = 0; b < NB; b++) begin
      int nv = 0;
      int nd = 0;
      for (int c = 0; c < NP; c++) begin
        if (cv[c][b]) nv++;
        if (cd[c][b]) nd++;
        if (cv[c][b]) chk(cdat[c][b] == golden[b], "R10", "cached copy is latest value", int'(cdat[c][b]), int'(golden[b]));
      end
      chk(nd == 0 || (nd == 1 && nv == 1), "R10", "single writer or readers", nv, nd);
    end
  endtask

  // driver: op 0 read miss, 1 write miss, 2 write-back
  task automatic do_req(input int c, input int b, input int op, input logic [DW-1:0] wd,
                        input string tag, input int exp_cmds);
    exp_t e;
    cur_src = c;
    cur_tag = tag;
    ncmd = 0;
    e.dst = SW'(c);
    e.blk = BW'(b);
    e.data = (op == 2) ? wd : golden[b];
    exp_q.push_back(e);
    @(negedge clk);
    req_src = SW'(c); req_blk = BW'(b); req_op = 2'(op); req_data = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "busy after accept", int'(req_ready), 0);
    while (exp_q.size() != 0) @(negedge clk);
    if (exp_cmds >= 0) chk(ncmd == exp_cmds, tag, "command count", ncmd, exp_cmds);
    if (op == 0) begin
      cv[c][b] = 1'b1; cdat[c][b] = golden[b];
    end else if (op == 1) begin
      cv[c][b] = 1'b1; cd[c][b] = 1'b1; cdat[c][b] = wd; golden[b] = wd;
    end else begin
      cv[c][b] = 1'b0; cd[c][b] = 1'b0;
    end
    check_invariant();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int c = 0; c < NP; c++)
      for (int b = 0; b < NB; b++) begin
        cv[c][b] = 1'b0; cd[c][b] = 1'b0; cdat[c][b] = '0;
      end
    for (int b = 0; b < NB; b++) golden[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    do_req(0, 0, 0, 8'h00, "R1", 0);
    do_req(1, 0, 0, 8'h00, "R2", 0);
    do_req(2, 0, 1, 8'h5A, "R3", 2);
    do_req(0, 0, 0, 8'h00, "R5", 1);
    do_req(1, 0, 1, 8'hC3, "R4", 2);
    do_req(2, 0, 1, 8'h3C, "R6", 1);
    do_req(2, 0, 2, cdat[2][0], "R7", 0);
    do_req(0, 0, 0, 8'h00, "R7", 0);
    do_req(1, 1, 1, 8'h11, "R2", 0);
    for (int n = 0; n < 400; n++) begin
      int c = $urandom_range(NP - 1);
      int b = $urandom_range(NB - 1);
      int r = $urandom_range(1);
      logic [DW-1:0] wd = DW'($urandom_range(255));
      if (cd[c][b]) begin
        if (r == 1) do_req(c, b, 2, cdat[c][b], "R10", 0);
      end else if (cv[c][b]) begin
        if (r == 1) do_req(c, b, 1, wd, "R10", -1);
      end else if (r == 1) begin
        do_req(c, b, 0, 8'h00, "R10", -1);
      end else begin
        do_req(c, b, 1, wd, "R10", -1);
      end
    end
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule